// File: doc/BRIEF.md
# Real-Time Clock Rate Divider

This block is the countdown chain of a real-time clock. A one-cycle clock enable at 32.768 kHz advances a 15-stage binary divider. A 4-bit rate code picks one divider tap. That single tap feeds two consumers: a square-wave pin and a periodic event pulse. Each consumer has its own enable, so the two can be used independently even though they always share a frequency. The most significant divider stage provides a 1 Hz carry pulse for the seconds counter that follows.

A 3-bit oscillator control field has three effects. It lets the chain count, or it freezes the chain where it stands, or it clamps every stage to zero. Software normally clamps the chain, programs the rate, and then releases the chain. The taps then restart from a known phase, and the first seconds carry arrives half a second after release.

Top module: `rtc_rate_divider`

## Requirements
- R1: A synchronous active-high `rst` clears the divider and drives `sqw_out`, `per_pulse` and `sec_carry` low on the following clock.
- R2: With `rate_sel` = 1 the selected tap period is 128 ticks, with 2 it is 256 ticks, and with codes n = 3..15 it is 2^(n-1) ticks (8192 Hz down to 2 Hz from a 32.768 kHz tick).
- R3: `rate_sel` = 0 selects no tap: `per_pulse` never fires and `sqw_out` stays low.
- R4: `per_pulse` is high for exactly one clock per rising edge of the selected tap. After the chain is released from hold with a tick on every clock, the first pulse is seen 2^(n-2)+1 clocks later for codes n = 3..15, because two register stages sit on the path.
- R5: `sqw_out` is a registered copy of the selected tap, high for half of each period. It is held low whenever `sqw_en` is 0.
- R6: `pie_en` gates only `per_pulse`, and `sqw_en` gates only `sqw_out`. Either output works while the other is disabled.
- R7: With `osc_ctl` = 3'b010 the divider advances only on clocks where `tick_en` is 1.
- R8: With `osc_ctl` = 3'b110 or 3'b111 the divider is held at zero and no events occur. On return to 3'b010 all taps restart from zero.
- R9: Any other `osc_ctl` value freezes the divider. `sqw_out` keeps its level and no events occur. Counting resumes from the frozen value when the control returns to 3'b010.
- R10: `sec_carry` is a one-clock pulse. The first one comes 16384 ticks after release from hold, seen at clock 16385 with a tick every clock, and later ones come every 32768 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | 32.768 kHz clock enable |
| osc_ctl | input | 3 | Oscillator control: 010 run, 11x hold at zero, others freeze |
| rate_sel | input | 4 | Tap select code shared by both outputs |
| sqw_en | input | 1 | Square-wave output enable |
| pie_en | input | 1 | Periodic event enable |
| sqw_out | output | 1 | Square wave at the selected rate |
| per_pulse | output | 1 | One-clock pulse per selected-tap rising edge |
| sec_carry | output | 1 | One-clock 1 Hz carry |

## Verification
A divider stage that is off by one count, or a tap wired to the wrong stage, shows up as a period between event pulses that is wrong by a factor of two. The fault is visible after the second pulse, which is at most a few thousand clocks away for the fast codes. A hold that fails to clear the chain moves the first pulse, and the first carry, after release. That fault is visible within 2^(n-2)+1 clocks. A freeze that leaks counts, or a gate on the wrong enable, produces a stray edge on `sqw_out` or `per_pulse` within one tap period.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;

  typedef enum logic [1:0] {
    OSC_OFF  = 2'd0,
    OSC_RUN  = 2'd1,
    OSC_HOLD = 2'd2
  } osc_mode_e;

  // Divider stage index driven by a rate code; -1 means no tap.
  function automatic int tap_of_code(input int code);
    if (code == 1)      return 6;
    else if (code == 2) return 7;
    else if (code >= 3) return code - 2;
    else                return -1;
  endfunction

endpackage

// File: rtl/osc_mode_decode.sv
module osc_mode_decode
  import rtc_div_pkg::*;
(
  input  logic [2:0] ctl,
  output osc_mode_e  mode
);

  always_comb begin
    casez (ctl)
      3'b010:  mode = OSC_RUN;
      3'b11?:  mode = OSC_HOLD;
      default: mode = OSC_OFF;
    endcase
  end

endmodule

// File: rtl/div_chain.sv
module div_chain
  import rtc_div_pkg::*;
#(
  parameter int STAGES = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  osc_mode_e         mode,
  output logic [STAGES-1:0] cnt_q
);

  localparam logic [STAGES-1:0] ONE = STAGES'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      case (mode)
        OSC_HOLD: cnt_q <= '0;
        OSC_RUN:  if (tick_en) cnt_q <= cnt_q + ONE;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  // R8: the hold mode leaves every stage at zero
  p_hold_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == OSC_HOLD) |=> (cnt_q == '0));

  // R9: a stopped oscillator freezes the chain
  p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (mode == OSC_OFF) |=> $stable(cnt_q));

  // R7: no count without a tick
  p_no_tick_no_count_r7: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && mode == OSC_RUN) |=> $stable(cnt_q));

endmodule

// File: rtl/tap_select.sv
module tap_select
  import rtc_div_pkg::*;
#(
  parameter int STAGES = 15,
  parameter int RS_W   = 4
) (
  input  logic [STAGES-1:0] cnt,
  input  logic [RS_W-1:0]   rs,
  output logic              tap
);

  localparam int NCODES = 2 ** RS_W;

  logic [NCODES-1:0] taps;
  logic unused_edges;

  assign unused_edges = cnt[0] ^ cnt[STAGES-1];

  for (genvar c = 0; c < NCODES; c++) begin : g_code
    localparam int TI = tap_of_code(c);
    if (TI >= 0 && TI < STAGES) begin : g_tap
      assign taps[c] = cnt[TI];
    end else begin : g_none
      assign taps[c] = 1'b0;
    end
  end

  assign tap = taps[rs];

endmodule

// File: rtl/event_stage.sv
module event_stage (
  input  logic clk,
  input  logic rst,
  input  logic tap,
  input  logic cnt_msb,
  input  logic sqw_en,
  input  logic pie_en,
  output logic sqw_out,
  output logic per_pulse,
  output logic sec_carry
);

  logic tap_d;
  logic msb_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_d     <= 1'b0;
      msb_d     <= 1'b0;
      sqw_out   <= 1'b0;
      per_pulse <= 1'b0;
      sec_carry <= 1'b0;
    end else begin
      tap_d     <= tap;
      msb_d     <= cnt_msb;
      sqw_out   <= sqw_en & tap;
      per_pulse <= pie_en & tap & ~tap_d;
      sec_carry <= cnt_msb & ~msb_d;
    end
  end

  // R4: each event lasts one clock
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
    per_pulse |=> !per_pulse);

  // R5: square wave low while disabled
  p_sqw_gated_r5: assert property (@(posedge clk) disable iff (rst)
    !sqw_en |=> !sqw_out);

  // R6: the event enable gates the pulse
  p_pie_gated_r6: assert property (@(posedge clk) disable iff (rst)
    !pie_en |=> !per_pulse);

  // R10: carry lasts one clock
  p_carry_single_r10: assert property (@(posedge clk) disable iff (rst)
    sec_carry |=> !sec_carry);

endmodule

// File: rtl/rtc_rate_divider.sv
module rtc_rate_divider
  import rtc_div_pkg::*;
#(
  parameter int STAGES = 15,
  parameter int RS_W   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_en,
  input  logic [2:0]      osc_ctl,
  input  logic [RS_W-1:0] rate_sel,
  input  logic            sqw_en,
  input  logic            pie_en,
  output logic            sqw_out,
  output logic            per_pulse,
  output logic            sec_carry
);

  osc_mode_e         mode;
  logic [STAGES-1:0] cnt;
  logic              tap;

  osc_mode_decode u_dec (
    .ctl  (osc_ctl),
    .mode (mode)
  );

  div_chain #(.STAGES(STAGES)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .mode    (mode),
    .cnt_q   (cnt)
  );

  tap_select #(.STAGES(STAGES), .RS_W(RS_W)) u_sel (
    .cnt (cnt),
    .rs  (rate_sel),
    .tap (tap)
  );

  event_stage u_evt (
    .clk       (clk),
    .rst       (rst),
    .tap       (tap),
    .cnt_msb   (cnt[STAGES-1]),
    .sqw_en    (sqw_en),
    .pie_en    (pie_en),
    .sqw_out   (sqw_out),
    .per_pulse (per_pulse),
    .sec_carry (sec_carry)
  );

  // R3: code zero keeps both outputs quiet
  p_rs_zero_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (rate_sel == '0) |=> (!per_pulse && !sqw_out));

endmodule

// File: tb/rtc_rate_divider_tb_top.sv
module rtc_rate_divider_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b1;
  logic [2:0] osc_ctl = 3'b000;
  logic [3:0] rate_sel = 4'd0;
  logic       sqw_en = 1'b0;
  logic       pie_en = 1'b0;
  logic       sqw_out, per_pulse, sec_carry;

  int checks = 0;
  int errors = 0;
  int tick_div = 1;

  always #4 clk = ~clk;

  rtc_rate_divider dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .osc_ctl(osc_ctl),
    .rate_sel(rate_sel), .sqw_en(sqw_en), .pie_en(pie_en),
    .sqw_out(sqw_out), .per_pulse(per_pulse), .sec_carry(sec_carry)
  );

  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % tick_div;
      tick_en = (ph == 0);
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic release_chain(input logic [3:0] rs);
    osc_ctl = 3'b110;
    cyc(3);
    rate_sel = rs;
    osc_ctl = 3'b010;
  endtask

  task automatic wait_pulse(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!per_pulse && n < limit);
  endtask

  task automatic wait_carry(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sec_carry && n < limit);
  endtask

  task automatic t_reset();
    osc_ctl = 3'b010; rate_sel = 4'd3; sqw_en = 1'b1; pie_en = 1'b1;
    rst = 1'b1;
    cyc(4);
    check("R1", "sqw_out in reset", int'(sqw_out), 0);
    check("R1", "per_pulse in reset", int'(per_pulse), 0);
    check("R1", "sec_carry in reset", int'(sec_carry), 0);
    rst = 1'b0;
  endtask

  task automatic t_rate(input logic [3:0] rs, input int k, input bit first);
    int n;
    pie_en = 1'b1;
    release_chain(rs);
    wait_pulse(40000, n);
    if (first) check("R4", $sformatf("first pulse latency rs=%0d", rs), n, (1 << k) + 1);
    @(negedge clk);
    check("R4", "pulse width one clock", int'(per_pulse), 0);
    wait_pulse(40000, n);
    check("R2", $sformatf("period rs=%0d", rs), n + 1, 1 << (k + 1));
  endtask

  task automatic t_sqw();
    int hi, lo, n, toggles;
    logic prev;
    sqw_en = 1'b1; pie_en = 1'b1;
    release_chain(4'd6);
    while (sqw_out) @(negedge clk);
    while (!sqw_out) @(negedge clk);
    hi = 0; while (sqw_out) begin hi++; @(negedge clk); end
    lo = 0; while (!sqw_out) begin lo++; @(negedge clk); end
    check("R5", "sqw high time", hi, 16);
    check("R5", "sqw low time", lo, 16);
    sqw_en = 1'b0;
    cyc(2);
    n = 0; toggles = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (sqw_out) n++;
      if (per_pulse) toggles++;
    end
    check("R5", "sqw high while disabled", n, 0);
    check("R6", "pulses with sqw disabled", toggles, 2);
    sqw_en = 1'b1; pie_en = 1'b0;
    cyc(2);
    n = 0; toggles = 0; prev = sqw_out;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (per_pulse) n++;
      if (sqw_out != prev) toggles++;
      prev = sqw_out;
    end
    check("R6", "pulses with event disabled", n, 0);
    check("R6", "sqw edges with event disabled", toggles, 5);
  endtask

  task automatic t_rs_zero();
    int p, s;
    sqw_en = 1'b1; pie_en = 1'b1;
    release_chain(4'd0);
    p = 0; s = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (per_pulse) p++;
      if (sqw_out) s++;
    end
    check("R3", "pulses with code zero", p, 0);
    check("R3", "sqw high with code zero", s, 0);
  endtask

  task automatic t_stop(input logic [2:0] code);
    int p, ch, n;
    logic lvl;
    sqw_en = 1'b1; pie_en = 1'b1;
    release_chain(4'd4);
    cyc(5);
    osc_ctl = code;
    cyc(2);
    lvl = sqw_out; p = 0; ch = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (per_pulse) p++;
      if (sqw_out != lvl) ch++;
    end
    check("R9", $sformatf("pulses while stopped code=%0d", code), p, 0);
    check("R9", "sqw level change while stopped", ch, 0);
    osc_ctl = 3'b010;
    wait_pulse(100, n);
    check("R9", "pulse after resume", int'(per_pulse), 1);
  endtask

  task automatic t_hold();
    int p, s, c, n;
    sqw_en = 1'b1; pie_en = 1'b1;
    rate_sel = 4'd3; osc_ctl = 3'b010;
    cyc(20);
    osc_ctl = 3'b111;
    cyc(3);
    p = 0; s = 0; c = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (per_pulse) p++;
      if (sqw_out) s++;
      if (sec_carry) c++;
    end
    check("R8", "pulses in hold", p, 0);
    check("R8", "sqw high in hold", s, 0);
    check("R8", "carry in hold", c, 0);
    osc_ctl = 3'b010;
    wait_pulse(100, n);
    check("R8", "restart latency after hold", n, 3);
  endtask

  task automatic t_tick_gate();
    int n;
    tick_div = 4;
    pie_en = 1'b1;
    release_chain(4'd3);
    wait_pulse(200, n);
    wait_pulse(200, n);
    check("R7", "period with tick every 4 clocks", n, 16);
    tick_div = 1;
    cyc(2);
  endtask

  task automatic t_carry();
    int n;
    release_chain(4'd15);
    wait_carry(40000, n);
    check("R10", "first carry latency", n, 16385);
    @(negedge clk);
    check("R10", "carry width one clock", int'(sec_carry), 0);
    wait_carry(40000, n);
    check("R10", "carry period", n + 1, 32768);
  endtask

  initial begin
    cyc(2);
    t_reset();
    t_rate(4'd3, 1, 1'b1);
    t_rate(4'd1, 6, 1'b0);
    t_rate(4'd2, 7, 1'b0);
    t_rate(4'd6, 4, 1'b1);
    t_rate(4'd15, 13, 1'b1);
    t_sqw();
    t_rs_zero();
    t_stop(3'b000);
    t_stop(3'b101);
    t_hold();
    t_tick_gate();
    t_carry();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule